// File: doc/BRIEF.md
# CSMA Transmit Keying Sequencer

This block decides when a half-duplex packet-radio transmitter may key up and what fill surrounds each frame on the air. It watches a frame-pending flag from the framer, the receiver's carrier detect and the radio's PTT feedback. It drives a PTT request, and on every byte slot the modulator offers, it names the source of the next byte: flag fill, frame data or zero fill.

Channel access uses slotted p-persistent CSMA. A slot counter runs on an external slot tick. A 16-bit LFSR supplies the random draw that is compared against the persistence setting. The lead-in and trailing flag runs are set in 10 ms units and converted to octet counts from the configured bit rate. A calibration request makes the block send a fixed number of zero bytes while it is otherwise quiet. A saturating counter records how many times the transmitter has been keyed.

Top module: `csma_key_sequencer`

## Requirements
- R1: After reset, ptt_o is 0, byte_strobe_o stays 0 even with byte_slot_i high, and keyup_count_o is 0.
- R2: On key-up, the lead-in length is floor(txdelay_i × bitrate_i / 800) octets. That many flag bytes are emitted, with byte_sel_o = 2'b01, one per cycle in which byte_slot_i is high. A length of 0 goes straight to data.
- R3: In half duplex (full_duplex_i = 0), the transmitter never keys up while carrier_i is 1, and the slot counter is reloaded with slottime_i on every such cycle.
- R4: In half duplex with a clear channel and a frame pending, each slot_tick_i decrements the slot counter. An access attempt happens on the tick that finds the counter at 1 or 0, which is the slottime_i-th clear tick after a reload, and the counter is then reloaded.
- R5: An access attempt keys up only if the low 8 bits of the LFSR are less than or equal to persist_i. The LFSR starts at 16'hACE1, shifts left and feeds bit15^bit13^bit12^bit10 into bit 0. It advances on every slot_tick_i in any state.
- R6: In full duplex, a pending frame keys up on the next clock edge, ignoring carrier, slot counter and persistence.
- R7: In the data state, each byte slot with frame_pending_i high emits a data byte (byte_sel_o = 2'b10). When frame_pending_i drops, the block enters the tail state.
- R8: The tail emits floor(txtail_i × bitrate_i / 800) flag bytes with ptt_o held at 1. Once they are sent, ptt_o goes to 0 and no further bytes are emitted.
- R9: A frame becoming pending during the tail returns the block to data without a new key-up. A later tail starts with a fresh length.
- R10: The tail ends in idle only when ptt_fb_i reads 0. While the radio still reports PTT, a new frame resumes data without a key-up.
- R11: A calibration load (cal_load_i with count cal_bytes_i, accepted in any state) makes the idle block emit that many zero bytes (byte_sel_o = 2'b00) with ptt_o at 1. No access attempt is made until they are sent.
- R12: keyup_count_o increments on every idle-to-keyup transition and holds at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_pending_i | input | 1 | Framer has frame bytes ready |
| carrier_i | input | 1 | Carrier detected on channel |
| ptt_fb_i | input | 1 | Radio reports transmitter keyed |
| byte_slot_i | input | 1 | Modulator accepts one byte this cycle |
| slot_tick_i | input | 1 | One CSMA slot period has elapsed |
| full_duplex_i | input | 1 | Skip carrier, slot and persistence checks |
| txdelay_i | input | PARAM_W | Lead-in length in 10 ms units |
| txtail_i | input | PARAM_W | Trailing length in 10 ms units |
| slottime_i | input | PARAM_W | Slot ticks between access attempts |
| persist_i | input | PARAM_W | Persistence threshold, 0 to 255 |
| bitrate_i | input | BR_W | Line bit rate in bit/s |
| cal_load_i | input | 1 | Load calibration byte count |
| cal_bytes_i | input | CAL_W | Number of zero bytes to send |
| ptt_o | output | 1 | PTT request to radio |
| byte_strobe_o | output | 1 | A byte is taken from the selected source |
| byte_sel_o | output | 2 | Byte source: 00 zero, 01 flag, 10 data |
| keyup_count_o | output | KEYUP_W | Saturating key-up count |

## Verification
A wrong state or length counter shows up within the very next byte slot as a wrong byte_sel_o or an extra or missing strobe, so the bench counts flag, data and zero strobes per phase and compares them with the bit-rate formula. A corrupted slot counter or LFSR only appears when a slot tick lands: a key-up arrives one tick early or late, or is granted against the wrong draw. The bench therefore tracks the LFSR sequence itself and checks keyup_count_o right after each tick. A tail that leaves before the radio drops PTT is invisible until the next frame. At that point it shows as a spurious key-up count and a fresh lead-in instead of immediate data.

// File: rtl/csma_key_pkg.sv
package csma_key_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_KEYUP, ST_DATA, ST_TAIL} key_state_e;
  typedef enum logic [1:0] {SRC_ZERO = 2'd0, SRC_FLAG = 2'd1, SRC_DATA = 2'd2} byte_src_e;
  // flag octets = 10 ms units * bit/s / 800
  localparam int unsigned FLAG_DIV = 800;
  // 800 > 2**9, so the quotient needs 9 bits fewer than the product
  localparam int unsigned FLAG_DIV_SHIFT = 9;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         advance_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else if (advance_i) q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign value_o = q;

  assert_lfsr_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
  assert_lfsr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(q));
endmodule

// File: rtl/csma_flag_len.sv
module csma_flag_len
  import csma_key_pkg::*;
#(
  parameter int unsigned PARAM_W = 8,
  parameter int unsigned BR_W    = 21,
  localparam int unsigned PROD_W = PARAM_W + BR_W,
  localparam int unsigned LEN_W  = PROD_W - FLAG_DIV_SHIFT
) (
  input  logic [PARAM_W-1:0] units_i,
  input  logic [BR_W-1:0]    bitrate_i,
  output logic [LEN_W-1:0]   len_o
);
  localparam logic [PROD_W-1:0] DIV_K = PROD_W'(FLAG_DIV);
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    prod  = PROD_W'(units_i) * PROD_W'(bitrate_i);
    quot  = prod / DIV_K;
    len_o = quot[LEN_W-1:0];
  end
endmodule

// File: rtl/csma_access_gate.sv
module csma_access_gate #(
  parameter int unsigned PARAM_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               full_duplex_i,
  input  logic               carrier_i,
  input  logic               slot_tick_i,
  input  logic [PARAM_W-1:0] slottime_i,
  input  logic [PARAM_W-1:0] persist_i,
  input  logic [PARAM_W-1:0] rand_i,
  output logic               grant_o
);
  logic [PARAM_W-1:0] slot_cnt_q;
  logic               slot_due;

  assign slot_due = slot_cnt_q <= PARAM_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_cnt_q <= '0;
    else if (!full_duplex_i) begin
      if (carrier_i) slot_cnt_q <= slottime_i;
      else if (enable_i && slot_tick_i)
        slot_cnt_q <= slot_due ? slottime_i : slot_cnt_q - PARAM_W'(1);
    end
  end

  assign grant_o = enable_i &&
                   (full_duplex_i ||
                    (!carrier_i && slot_tick_i && slot_due && (rand_i <= persist_i)));

  assert_carrier_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carrier_i && !full_duplex_i) |=> slot_cnt_q == $past(slottime_i));
  assert_slot_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !full_duplex_i && !carrier_i && slot_tick_i && !slot_due)
      |=> slot_cnt_q == $past(slot_cnt_q) - PARAM_W'(1));
endmodule

// File: rtl/csma_key_sequencer.sv
module csma_key_sequencer
  import csma_key_pkg::*;
#(
  parameter int unsigned PARAM_W = 8,
  parameter int unsigned BR_W    = 21,
  parameter int unsigned CAL_W   = 16,
  parameter int unsigned KEYUP_W = 16,
  parameter int unsigned LFSR_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_pending_i,
  input  logic               carrier_i,
  input  logic               ptt_fb_i,
  input  logic               byte_slot_i,
  input  logic               slot_tick_i,
  input  logic               full_duplex_i,
  input  logic [PARAM_W-1:0] txdelay_i,
  input  logic [PARAM_W-1:0] txtail_i,
  input  logic [PARAM_W-1:0] slottime_i,
  input  logic [PARAM_W-1:0] persist_i,
  input  logic [BR_W-1:0]    bitrate_i,
  input  logic               cal_load_i,
  input  logic [CAL_W-1:0]   cal_bytes_i,
  output logic               ptt_o,
  output logic               byte_strobe_o,
  output logic [1:0]         byte_sel_o,
  output logic [KEYUP_W-1:0] keyup_count_o
);
  localparam int unsigned LEN_W = PARAM_W + BR_W - FLAG_DIV_SHIFT;

  key_state_e         state_q, state_d;
  logic [LEN_W-1:0]   flag_cnt_q, flag_cnt_d;
  logic [CAL_W-1:0]   cal_cnt_q, cal_cnt_d;
  logic [KEYUP_W-1:0] keyup_cnt_q, keyup_cnt_d;
  logic [LEN_W-1:0]   delay_len, tail_len;
  logic [LFSR_W-1:0]  lfsr_val;
  logic               cal_active, access_en, grant;
  byte_src_e          sel;

  csma_flag_len #(.PARAM_W(PARAM_W), .BR_W(BR_W)) u_delay_len (
    .units_i(txdelay_i), .bitrate_i(bitrate_i), .len_o(delay_len));

  csma_flag_len #(.PARAM_W(PARAM_W), .BR_W(BR_W)) u_tail_len (
    .units_i(txtail_i), .bitrate_i(bitrate_i), .len_o(tail_len));

  csma_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .advance_i(slot_tick_i), .value_o(lfsr_val));

  assign cal_active = cal_cnt_q != '0;
  assign access_en  = (state_q == ST_IDLE) && frame_pending_i && !cal_active;

  csma_access_gate #(.PARAM_W(PARAM_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(access_en),
    .full_duplex_i(full_duplex_i), .carrier_i(carrier_i),
    .slot_tick_i(slot_tick_i), .slottime_i(slottime_i),
    .persist_i(persist_i), .rand_i(lfsr_val[PARAM_W-1:0]), .grant_o(grant));

  always_comb begin
    state_d       = state_q;
    flag_cnt_d    = flag_cnt_q;
    cal_cnt_d     = cal_cnt_q;
    keyup_cnt_d   = keyup_cnt_q;
    byte_strobe_o = 1'b0;
    sel           = SRC_ZERO;
    ptt_o         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cal_active) begin
          ptt_o = 1'b1;
          if (byte_slot_i) begin
            byte_strobe_o = 1'b1;
            sel           = SRC_ZERO;
            cal_cnt_d     = cal_cnt_q - CAL_W'(1);
          end
        end else if (grant) begin
          state_d    = ST_KEYUP;
          flag_cnt_d = delay_len;
          if (!(&keyup_cnt_q)) keyup_cnt_d = keyup_cnt_q + KEYUP_W'(1);
        end
      end
      ST_KEYUP: begin
        ptt_o = 1'b1;
        if (flag_cnt_q == '0) state_d = ST_DATA;
        else if (byte_slot_i) begin
          byte_strobe_o = 1'b1;
          sel           = SRC_FLAG;
          flag_cnt_d    = flag_cnt_q - LEN_W'(1);
          if (flag_cnt_q == LEN_W'(1)) state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        ptt_o = 1'b1;
        if (frame_pending_i) begin
          if (byte_slot_i) begin
            byte_strobe_o = 1'b1;
            sel           = SRC_DATA;
          end
        end else begin
          state_d    = ST_TAIL;
          flag_cnt_d = tail_len;
        end
      end
      ST_TAIL: begin
        if (frame_pending_i) begin
          ptt_o   = 1'b1;
          state_d = ST_DATA;
        end else if (flag_cnt_q != '0) begin
          ptt_o = 1'b1;
          if (byte_slot_i) begin
            byte_strobe_o = 1'b1;
            sel           = SRC_FLAG;
            flag_cnt_d    = flag_cnt_q - LEN_W'(1);
          end
        end else if (!ptt_fb_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (cal_load_i) cal_cnt_d = cal_bytes_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      flag_cnt_q  <= '0;
      cal_cnt_q   <= '0;
      keyup_cnt_q <= '0;
    end else begin
      state_q     <= state_d;
      flag_cnt_q  <= flag_cnt_d;
      cal_cnt_q   <= cal_cnt_d;
      keyup_cnt_q <= keyup_cnt_d;
    end
  end

  assign byte_sel_o    = sel;
  assign keyup_count_o = keyup_cnt_q;

  assert_tail_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_TAIL) |-> !$past(ptt_fb_i));
  assert_lead_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_KEYUP) |-> $past(flag_cnt_q) <= LEN_W'(1));
  assert_keyup_count_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_KEYUP && $past(state_q) == ST_IDLE) |->
      ((&$past(keyup_cnt_q)) ? keyup_cnt_q == $past(keyup_cnt_q)
                             : keyup_cnt_q == $past(keyup_cnt_q) + KEYUP_W'(1)));
  assert_cal_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_KEYUP && $past(state_q) == ST_IDLE) |-> $past(cal_cnt_q) == '0);
  assert_clear_channel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_KEYUP && $past(state_q) == ST_IDLE) |->
      ($past(full_duplex_i) || !$past(carrier_i)));
endmodule

// File: tb/csma_key_sequencer_bench.sv
`timescale 1ns/1ps
module csma_key_sequencer_bench;
  localparam int KW = 4;
  localparam int KMAX = (1 << KW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pending = 0, carrier = 0, ptt_fb = 0, byte_slot = 0, slot_tick = 0, fd = 0;
  logic [7:0] txdelay = 0, txtail = 0, slottime = 0, persist = 0;
  logic [20:0] bitrate = 21'd1200;
  logic cal_load = 0;
  logic [15:0] cal_bytes = 0;
  logic ptt, strobe;
  logic [1:0] sel;
  logic [KW-1:0] keyups;

  int n_chk = 0, n_fail = 0, flag_n = 0, data_n = 0, zero_n = 0, keyup_exp = 0;
  int cyc = 0;
  bit done = 0;
  logic [15:0] lfsr_m = 16'hACE1;

  csma_key_sequencer #(.KEYUP_W(KW)) u_csma_key_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .frame_pending_i(pending), .carrier_i(carrier),
    .ptt_fb_i(ptt_fb), .byte_slot_i(byte_slot), .slot_tick_i(slot_tick),
    .full_duplex_i(fd), .txdelay_i(txdelay), .txtail_i(txtail),
    .slottime_i(slottime), .persist_i(persist), .bitrate_i(bitrate),
    .cal_load_i(cal_load), .cal_bytes_i(cal_bytes), .ptt_o(ptt),
    .byte_strobe_o(strobe), .byte_sel_o(sel), .keyup_count_o(keyups));

  always #5 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  always @(negedge clk) if (rst_n && strobe) begin
    case (sel)
      2'b00: zero_n++;
      2'b01: flag_n++;
      2'b10: data_n++;
      default: begin n_chk++; n_fail++; $display("FAIL R7 select: actual %0d expected %0d", sel, 2); end
    endcase
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flags_for(int units, int br);
    return (units * br) / 800;
  endfunction

  function automatic int sat_k(int n);
    return (n > KMAX) ? KMAX : n;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_tick();
    step(); slot_tick = 1;
    step(); slot_tick = 0;
    lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
  endtask

  task automatic clear_counts();
    flag_n = 0; data_n = 0; zero_n = 0;
  endtask

  task automatic wait_ptt_low();
    int g = 0;
    do begin @(negedge clk); g++; end while (ptt && g < 20000);
    step();
  endtask

  task automatic run_fd(int td, int tt, int br, int nb);
    int g = 0, snap;
    step();
    fd = 1; carrier = 0; byte_slot = 1; ptt_fb = 1;
    txdelay = 8'(td); txtail = 8'(tt); bitrate = 21'(br);
    clear_counts(); pending = 1;
    while (data_n < nb && g < 20000) begin step(); g++; end
    pending = 0; snap = flag_n;
    check(snap == flags_for(td, br), "R2 lead-in flags", snap, flags_for(td, br));
    check(data_n == nb, "R7 data bytes", data_n, nb);
    wait_ptt_low();
    check(flag_n - snap == flags_for(tt, br), "R8 tail flags", flag_n - snap, flags_for(tt, br));
    keyup_exp++;
    check(keyups == KW'(sat_k(keyup_exp)), "R12 keyup count", keyups, sat_k(keyup_exp));
    snap = flag_n + data_n + zero_n;
    repeat (3) step();
    check(!ptt, "R8 ptt released", ptt, 0);
    check(flag_n + data_n + zero_n == snap, "R8 no bytes after tail", flag_n + data_n + zero_n, snap);
    ptt_fb = 0; repeat (2) step();
  endtask

  initial begin
    int k0, d0, f0, seed_set, g, exp_grant;
    seed_set = $urandom(1234);
    byte_slot = 1;
    repeat (3) @(negedge clk);
    check(!ptt, "R1 reset ptt", ptt, 0);
    check(!strobe, "R1 reset strobe", strobe, 0);
    check(keyups == 0, "R1 reset keyups", keyups, 0);
    step(); rst_n = 1;
    repeat (2) step();
    check(!ptt && !strobe, "R1 idle after reset", {ptt, strobe}, 0);

    // R2/R6 directed lengths, incl. fractional and zero lead-in
    run_fd(3, 2, 9600, 4);
    run_fd(1, 1, 1200, 2);
    run_fd(2, 0, 300, 1);
    for (int i = 0; i < 20; i++)
      run_fd($urandom_range(0, 30), $urandom_range(0, 30), $urandom_range(300, 38400), $urandom_range(1, 6));

    // R9: frame during active tail; R10: frame while radio still keyed
    step();
    fd = 1; byte_slot = 1; ptt_fb = 1; txdelay = 0; txtail = 10; bitrate = 21'd8000;
    clear_counts(); pending = 1;
    g = 0; while (data_n < 3 && g < 100) begin step(); g++; end
    pending = 0; keyup_exp++;
    repeat (6) step();
    k0 = keyups; d0 = data_n;
    pending = 1; repeat (3) step();
    check(keyups == KW'(k0), "R9 no keyup on tail resume", keyups, k0);
    check(data_n > d0, "R9 data resumes", data_n, d0 + 1);
    pending = 0; f0 = flag_n;
    wait_ptt_low();
    check(flag_n - f0 == 100, "R9 fresh tail length", flag_n - f0, 100);
    repeat (4) step();
    check(!ptt, "R10 ptt low while waiting", ptt, 0);
    k0 = keyups; d0 = data_n;
    pending = 1; repeat (3) step();
    check(keyups == KW'(k0), "R10 waits on feedback", keyups, k0);
    check(data_n > d0, "R10 data resumes", data_n, d0 + 1);
    pending = 0; f0 = flag_n;
    wait_ptt_low();
    ptt_fb = 0; repeat (2) step();
    check(keyups == KW'(sat_k(keyup_exp)), "R10 keyup count", keyups, sat_k(keyup_exp));

    // R3/R4 half duplex
    step();
    fd = 0; byte_slot = 0; txdelay = 0; txtail = 0; ptt_fb = 0;
    slottime = 3; persist = 255; carrier = 1; pending = 1;
    repeat (6) pulse_tick();
    check(keyups == KW'(sat_k(keyup_exp)), "R3 busy channel no keyup", keyups, sat_k(keyup_exp));
    check(!ptt, "R3 ptt off while busy", ptt, 0);
    step(); carrier = 0;
    pulse_tick(); pulse_tick();
    check(keyups == KW'(sat_k(keyup_exp)), "R4 no attempt before slot", keyups, sat_k(keyup_exp));
    pulse_tick();
    keyup_exp++;
    check(keyups == KW'(sat_k(keyup_exp)), "R4 attempt on slot expiry", keyups, sat_k(keyup_exp));
    pending = 0; repeat (4) step();

    // R5 persistence against modelled LFSR
    slottime = 1; carrier = 1; step(); carrier = 0; pending = 1;
    for (int i = 0; i < 40; i++) begin
      persist = 8'($urandom_range(0, 255));
      exp_grant = (lfsr_m[7:0] <= persist) ? 1 : 0;
      pulse_tick();
      keyup_exp += exp_grant;
      check(keyups == KW'(sat_k(keyup_exp)), "R5 persistence draw", keyups, sat_k(keyup_exp));
      if (exp_grant != 0) begin
        pending = 0; repeat (4) step(); pending = 1;
      end
    end
    pending = 0; repeat (2) step();

    // R11 calibration
    fd = 1; byte_slot = 1; carrier = 0; txdelay = 0; txtail = 0; ptt_fb = 0;
    clear_counts(); cal_bytes = 16'd5; cal_load = 1;
    step(); cal_load = 0; pending = 1;
    check(ptt, "R11 ptt during calibration", ptt, 1);
    k0 = keyups;
    repeat (5) step();
    check(zero_n == 5, "R11 zero bytes", zero_n, 5);
    check(keyups == KW'(k0), "R11 no access during calibration", keyups, k0);
    repeat (2) step();
    keyup_exp++;
    check(keyups == KW'(sat_k(keyup_exp)), "R11 access after calibration", keyups, sat_k(keyup_exp));
    pending = 0; repeat (5) step();

    check(keyup_exp > KMAX && keyups == KW'(KMAX), "R12 saturation", keyups, KMAX);
    summary();
  end
endmodule